// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital timing and counting core of a dual-slope integrating analog-to-digital converter. A single period counter steps the converter through three phases: auto-zero, signal integrate and reference deintegrate. A one-hot phase output drives the analog switch selection. At the end of signal integrate the block takes the comparator level as the input polarity. That polarity selects the sign of the reference applied during deintegrate. The block then counts deintegrate clocks until the comparator changes state.

When deintegrate ends, the count, the sign and an over-range flag are loaded together into a result register. The bus interface that follows therefore always reads a coherent word. A run/hold input chooses between back-to-back conversions and parking in auto-zero a fixed 7 clocks before the next integrate phase. A status output spans integrate and deintegrate so that external circuitry can synchronise to the conversion.

The resolution parameter `RES_BITS` (N) sets the timing. Integrate lasts 2^(N-1) clocks and deintegrate lasts at most 2^N clocks. Auto-zero fills the rest of a 2^(N+1)-clock period.

Top module: `dsadc_sequencer`

## Requirements
- R1: After reset, `phase_sel` shows auto-zero (value 3'b001), and `status`, `result`, `sign` and `over_range` are all 0.
- R2: `phase_sel` is always one-hot, with bit 0 = auto-zero, bit 1 = integrate and bit 2 = deintegrate.
- R3: Signal integrate lasts exactly 2^(N-1) clocks.
- R4: The comparator level on the last integrate clock becomes the polarity, where 1 means a positive input. `ref_sel` carries this polarity throughout deintegrate, and `sign` latches it even when the count is zero.
- R5: Deintegrate ends on the first clock whose comparator level differs from the polarity. If that happens on the deintegrate clock with index k (counting from 0), then `result` = k, `over_range` = 0 and deintegrate lasted k+1 clocks.
- R6: If the comparator level does not change within 2^N deintegrate clocks, deintegrate ends after exactly 2^N clocks with `over_range` = 1 and `result` = 2^N-1 (all ones).
- R7: `result`, `sign` and `over_range` change only on the clock edge that ends deintegrate. They hold their values through auto-zero, integrate and deintegrate.
- R8: `status` is 1 during integrate and deintegrate, and 0 during auto-zero.
- R9: While `run_hold` stays 1, successive integrate phases start exactly 2^(N+1) clocks apart.
- R10: When `run_hold` is 0, a conversion in progress still completes, and the sequencer then parks in auto-zero. Integrate begins 7 clocks after `run_hold` is seen at 1 again. The same 7-clock lead applies after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_hold | input | 1 | 1 = run continuously, 0 = park in auto-zero |
| comp_in | input | 1 | Comparator output level |
| phase_sel | output | 3 | One-hot phase: {deintegrate, integrate, auto-zero} |
| ref_sel | output | 1 | Polarity that selects the reference sign during deintegrate |
| status | output | 1 | High during integrate and deintegrate |
| result | output | RES_BITS | Latched deintegrate count |
| sign | output | 1 | Latched polarity, 1 = positive |
| over_range | output | 1 | Latched over-range flag |

## Verification
A wrong period count would show up as an integrate phase of the wrong length. It would also move the start of the next integrate, and both effects appear at `phase_sel` within one conversion period. A wrong polarity or deintegrate count would go unseen while the conversion runs, because the result register is loaded only at the end of deintegrate. It becomes visible on `result`, `sign` and `over_range` on the first auto-zero clock. A fault in the hold logic would appear as auto-zero lasting too long or too short after `run_hold` is raised, and the mismatch would be within 7 clocks.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;
endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
    import dsadc_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_hold,
    input  logic   deint_done,
    output phase_e phase,
    output logic   int_last
);
    localparam int CW     = RES_BITS + 1;
    localparam int HALF   = 1 << (RES_BITS - 1);
    localparam int PERIOD = 1 << (RES_BITS + 1);
    localparam int PARK   = PERIOD - 7;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cyc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        int_last = 1'b0;
        case (st_q.phase)
            PH_INT: begin
                st_d.cyc = st_q.cyc + 1'b1;
                if (st_q.cyc == CW'(HALF - 1)) begin
                    st_d.phase = PH_DEINT;
                    int_last   = 1'b1;
                end
            end
            PH_DEINT: begin
                st_d.cyc = st_q.cyc + 1'b1;
                if (deint_done) st_d.phase = PH_AZ;
            end
            default: begin
                if (st_q.cyc == CW'(PARK) && !run_hold) begin
                    st_d.cyc = st_q.cyc;
                end else if (st_q.cyc == CW'(PERIOD - 1)) begin
                    st_d.cyc   = '0;
                    st_d.phase = PH_INT;
                end else begin
                    st_d.cyc = st_q.cyc + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_AZ;
            st_q.cyc   <= CW'(PARK);
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

    // R3: integrate continues until its final count
    p_int_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_INT && st_q.cyc != CW'(HALF - 1)) |=> st_q.phase == PH_INT);

    // R10: parked sequencer stays put while hold is requested
    p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_AZ && st_q.cyc == CW'(PARK) && !run_hold)
            |=> (st_q.phase == PH_AZ && $stable(st_q.cyc)));
endmodule

// File: rtl/dsadc_deint_counter.sv
module dsadc_deint_counter
    import dsadc_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              phase,
    input  logic                int_last,
    input  logic                comp_in,
    output logic                done,
    output logic                over,
    output logic                pol,
    output logic [RES_BITS-1:0] count
);
    localparam logic [RES_BITS-1:0] FULL = '1;

    typedef struct packed {
        logic [RES_BITS-1:0] cnt;
        logic                pol;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = (phase == PH_DEINT) && ((comp_in != st_q.pol) || (st_q.cnt == FULL));
        over = (comp_in == st_q.pol);
        if (int_last) begin
            st_d.pol = comp_in;
            st_d.cnt = '0;
        end else if (phase == PH_DEINT && !done) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol   = st_q.pol;
    assign count = st_q.cnt;

    // R6: deintegrate never runs past full scale
    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEINT && st_q.cnt == FULL) |=> phase != PH_DEINT);

    // R4: polarity is frozen during deintegrate
    p_pol_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEINT) |=> (phase != PH_DEINT || $stable(st_q.pol)));
endmodule

// File: rtl/dsadc_result_latch.sv
module dsadc_result_latch #(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RES_BITS-1:0] count_in,
    input  logic                pol_in,
    input  logic                over_in,
    output logic [RES_BITS-1:0] result,
    output logic                sign,
    output logic                over_range
);
    typedef struct packed {
        logic [RES_BITS-1:0] val;
        logic                sgn;
        logic                ovr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = count_in;
            st_d.sgn = pol_in;
            st_d.ovr = over_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result     = st_q.val;
    assign sign       = st_q.sgn;
    assign over_range = st_q.ovr;

    // R7: output word only moves on a load
    p_latch_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(st_q.val) && $stable(st_q.sgn) && $stable(st_q.ovr)));
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_hold,
    input  logic                comp_in,
    output logic [2:0]          phase_sel,
    output logic                ref_sel,
    output logic                status,
    output logic [RES_BITS-1:0] result,
    output logic                sign,
    output logic                over_range
);
    phase_e              phase;
    logic                int_last;
    logic                deint_done;
    logic                over_now;
    logic                pol;
    logic [RES_BITS-1:0] count;

    initial begin
        if (RES_BITS < 4) $error("RES_BITS must be at least 4");
    end

    dsadc_phase_ctrl #(.RES_BITS(RES_BITS)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_hold   (run_hold),
        .deint_done (deint_done),
        .phase      (phase),
        .int_last   (int_last)
    );

    dsadc_deint_counter #(.RES_BITS(RES_BITS)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .int_last (int_last),
        .comp_in  (comp_in),
        .done     (deint_done),
        .over     (over_now),
        .pol      (pol),
        .count    (count)
    );

    dsadc_result_latch #(.RES_BITS(RES_BITS)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (deint_done),
        .count_in   (count),
        .pol_in     (pol),
        .over_in    (over_now),
        .result     (result),
        .sign       (sign),
        .over_range (over_range)
    );

    assign phase_sel = {phase == PH_DEINT, phase == PH_INT, phase == PH_AZ};
    assign ref_sel   = pol;
    assign status    = (phase != PH_AZ);

    // R2: exactly one switch group selected
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(phase_sel));

    // R8: status falls only when entering auto-zero from deintegrate
    p_status_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status && deint_done) |=> !status);
endmodule

// File: tb/test_dsadc_sequencer.sv
module test_dsadc_sequencer;
    localparam int N      = 6;
    localparam int FS     = 1 << N;
    localparam int HALF   = 1 << (N - 1);
    localparam int PERIOD = 1 << (N + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_hold = 1'b1;
    logic         comp_in = 1'b0;
    logic [2:0]   phase_sel;
    logic         ref_sel;
    logic         status;
    logic [N-1:0] result;
    logic         sign;
    logic         over_range;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    int last_int_start = 0;
    bit prev_valid = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    dsadc_sequencer #(.RES_BITS(N)) i_dsadc_sequencer (
        .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .comp_in(comp_in),
        .phase_sel(phase_sel), .ref_sel(ref_sel), .status(status),
        .result(result), .sign(sign), .over_range(over_range)
    );

    function automatic int exp_count(int k);
        return (k < FS) ? k : FS - 1;
    endfunction
    function automatic int exp_over(int k);
        return (k < FS) ? 0 : 1;
    endfunction
    function automatic int exp_len(int k);
        return (k < FS) ? k + 1 : FS;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic run_conv(int k, bit s, bit drop_hold);
        int n_int;
        int n_de;
        int hold_res;
        bit hold_sgn;
        bit hold_ovr;
        bit bad_stat;
        bit bad_latch;
        bad_stat  = 0;
        bad_latch = 0;
        hold_res  = int'(result);
        hold_sgn  = sign;
        hold_ovr  = over_range;
        while (!phase_sel[1]) begin
            if (status) bad_stat = 1;
            @(negedge clk);
        end
        if (prev_valid)
            chk(cyc_cnt - last_int_start == PERIOD, "R9 period",
                cyc_cnt - last_int_start, PERIOD);
        last_int_start = cyc_cnt;
        prev_valid = !drop_hold;
        if (drop_hold) run_hold = 1'b0;
        comp_in = s;
        n_int = 0;
        while (phase_sel[1]) begin
            if (!status) bad_stat = 1;
            if (int'(result) != hold_res || sign != hold_sgn || over_range != hold_ovr) bad_latch = 1;
            n_int++;
            @(negedge clk);
        end
        chk(n_int == HALF, "R3 integrate length", n_int, HALF);
        n_de = 0;
        while (phase_sel[2]) begin
            if (!status) bad_stat = 1;
            if (int'(result) != hold_res || sign != hold_sgn || over_range != hold_ovr) bad_latch = 1;
            if (ref_sel != s) begin
                chk(0, "R4 ref_sel", int'(ref_sel), int'(s));
            end
            comp_in = (n_de >= k) ? !s : s;
            n_de++;
            @(negedge clk);
        end
        comp_in = 1'b0;
        chk(phase_sel == 3'b001, "R2 auto-zero onehot", int'(phase_sel), 1);
        chk(n_de == exp_len(k), "R5/R6 deintegrate length", n_de, exp_len(k));
        chk(int'(result) == exp_count(k), (k < FS) ? "R5 result" : "R6 result",
            int'(result), exp_count(k));
        chk(int'(over_range) == exp_over(k), "R6 over_range", int'(over_range), exp_over(k));
        chk(sign == s, "R4 sign", int'(sign), int'(s));
        chk(!bad_stat, "R8 status during phases", int'(bad_stat), 0);
        chk(!bad_latch, "R7 latch stable during conversion", int'(bad_latch), 0);
        chk(!status, "R8 status low in auto-zero", int'(status), 0);
    endtask

    task automatic check_resume(string tag);
        int n;
        n = 0;
        run_hold = 1'b1;
        while (!phase_sel[1] && n < 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(n == 7, tag, n, 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", cyc_cnt, 0);
        finish_run();
    end

    initial begin
        bit parked_ok;
        void'($urandom(32'd20240611));
        run_hold = 1'b1;
        repeat (3) @(negedge clk);
        chk(phase_sel == 3'b001, "R1 reset phase", int'(phase_sel), 1);
        chk(!status && result == '0 && !sign && !over_range, "R1 reset outputs",
            int'({status, sign, over_range}) + int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: 7-clock lead after reset (one posedge already elapsed)
        begin
            int n;
            n = 1;
            while (!phase_sel[1] && n < 20) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
            chk(n == 7, "R10 lead after reset", n, 7);
        end
        // directed corners
        run_conv(0, 1'b1, 0);
        run_conv(0, 1'b0, 0);
        run_conv(FS - 1, 1'b1, 0);
        run_conv(FS, 1'b0, 0);
        run_conv(FS + 40, 1'b1, 0);
        run_conv(1, 1'b0, 0);
        // random patterns
        for (int i = 0; i < 20; i++) begin
            int k;
            k = int'($urandom_range(0, FS + 8));
            run_conv(k, 1'($urandom_range(0, 1)), 0);
        end
        // hold: drop run_hold mid-conversion, R10
        run_conv(17, 1'b1, 1);
        parked_ok = 1;
        for (int i = 0; i < 300; i++) begin
            if (phase_sel != 3'b001 || status) parked_ok = 0;
            @(negedge clk);
        end
        chk(parked_ok, "R10 parked in auto-zero", int'(parked_ok), 1);
        chk(result == N'(17) && sign, "R10 result kept while parked", int'(result), 17);
        check_resume("R10 lead after release");
        run_conv(5, 1'b0, 0);
        run_conv(30, 1'b1, 0);
        finish_run();
    end
endmodule